// File: doc/BRIEF.md
# SCL Clock-Low Timeout Monitor

This block watches the clock line of a two-wire serial bus and reports when a device holds that line low for too long. The raw line level first passes through a synchronizer. A down-counter is loaded from a programmable limit. While the synchronized line stays low, the counter steps down once per tick of an internal prescaled timebase. Any high level on the line, even one that lasts a single cycle, restarts the count from the limit. The count therefore measures one unbroken low period, never the sum of several.

When the count runs out, a sticky status flag is set. Software clears it with a write-one-to-clear strobe, and a maskable interrupt is derived from it. The counter then rests at zero until the line goes high or the monitor is disabled. A limit of zero turns detection off. The live count is brought out so that firmware can see how much of the allowance is left.

Top module: `scl_lowtime_monitor`

## Requirements
- R1: The raw `scl_in` passes through a two-stage synchronizer. When `scl_in` falls and stays low, with the limit N nonzero and the block enabled, `timeout_status` rises exactly 2 + PRESCALE*N clock edges after the edge that first samples the low level, and not before.
- R2: While the synchronized line is low and the block is enabled, `live_count` drops by one every PRESCALE cycles. W edges after the low level is first sampled (W >= 2), it equals N - floor((W-2)/PRESCALE), floored at 0.
- R3: A synchronized high level reloads `live_count` from `timeout_val` and restarts the prescaler. A high pulse on `scl_in` that lasts a single cycle therefore restarts the full timeout from the next falling level.
- R4: At expiry the counter holds at 0 and does not wrap. While the line stays low, no second expiry event occurs.
- R5: `timeout_status` is sticky until `status_clr` is asserted for a cycle, which clears it. When a clear and an expiry fall on the same edge, the clear wins and the status reads 0.
- R6: `timeout_irq` is high exactly when `timeout_status` is 1 and `irq_mask` is 1.
- R7: With `timeout_val` equal to 0, the status is never set, however long the line stays low.
- R8: With `enable` low, `live_count` follows `timeout_val`, no decrement takes place and no expiry occurs. Once `enable` is raised with the line already low, expiry follows PRESCALE*N edges later.
- R9: During reset, `timeout_status`, `timeout_irq` and `live_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw clock-line level from the pad |
| enable | input | 1 | Monitor enable |
| timeout_val | input | CNT_W | Timeout limit in prescaler ticks; 0 disables detection |
| irq_mask | input | 1 | Interrupt mask, 1 lets the status through |
| status_clr | input | 1 | Write-one-to-clear strobe for the status flag |
| timeout_status | output | 1 | Sticky raw timeout status |
| timeout_irq | output | 1 | Masked timeout interrupt |
| live_count | output | CNT_W | Current counter value |

## Verification
Each timeout is probed one edge before and exactly at its predicted expiry edge. An off-by-one in the synchronizer depth or the prescaler wrap would set the status a cycle early or late. A one-cycle high glitch is injected partway through a low period: a design that paused instead of reloading, or that let the prescaler phase carry over, would expire too soon. The bench lines up a clear strobe with the expiry edge, where a design that gives the set priority would leave the flag raised. It then holds the line low afterwards, where a counter that wraps would fire a second time. A zero limit, a disabled monitor and a masked interrupt are each checked, because a design that mishandles any of them would raise a spurious interrupt.

// File: rtl/sclmon_pkg.sv
package sclmon_pkg;

  // Saturating decrement: stays at zero instead of wrapping.
  function automatic logic [63:0] sat_dec(input logic [63:0] v);
    return (v == 64'd0) ? 64'd0 : v - 64'd1;
  endfunction

  // Modulo increment of the prescale phase.
  function automatic logic [31:0] phase_next(input logic [31:0] ph, input logic [31:0] last);
    return (ph == last) ? 32'd0 : ph + 32'd1;
  endfunction

endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_sync
);
  logic [STAGES-1:0] shreg;

  // Idle level of the bus line is high, so the chain resets to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '1;
    else        shreg <= {shreg[STAGES-2:0], d_in};
  end

  assign d_sync = shreg[STAGES-1];
endmodule

// File: rtl/tick_gen.sv
module tick_gen
  import sclmon_pkg::*;
#(
  parameter int PRESCALE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] phase;
  logic [31:0]   phase_nx;

  assign phase_nx = phase_next(32'(phase), 32'(LAST));

  // Phase restarts whenever a low period is not in progress.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (!run) phase <= '0;
    else           phase <= phase_nx[PW-1:0];
  end

  assign tick = run && (phase == LAST);

  // R2
  tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick);
endmodule

// File: rtl/low_counter.sv
module low_counter
  import sclmon_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire_evt
);
  logic [63:0] dec_val;

  assign dec_val    = sat_dec(64'(count));
  assign expire_evt = run && tick && (count == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (!run) count <= load_val;
    else if (tick) count <= dec_val[CNT_W-1:0];
  end

  // R2
  count_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> (count <= $past(count)));

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == $past(load_val)));

  // R4
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && count == '0) |=> (count == '0));

  // R4
  single_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> !expire_evt);
endmodule

// File: rtl/scl_lowtime_monitor.sv
module scl_lowtime_monitor #(
  parameter int CNT_W       = 16,
  parameter int PRESCALE    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             enable,
  input  logic [CNT_W-1:0] timeout_val,
  input  logic             irq_mask,
  input  logic             status_clr,
  output logic             timeout_status,
  output logic             timeout_irq,
  output logic [CNT_W-1:0] live_count
);
  logic scl_s;
  logic low_run;
  logic tick;
  logic expire_evt;
  logic status_q;

  scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_in   (scl_in),
    .d_sync (scl_s)
  );

  // A low period counts only when enabled with a nonzero limit.
  assign low_run = enable && !scl_s && (timeout_val != '0);

  tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (low_run),
    .tick  (tick)
  );

  low_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (low_run),
    .tick       (tick),
    .load_val   (timeout_val),
    .count      (live_count),
    .expire_evt (expire_evt)
  );

  // Clear beats set on the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          status_q <= 1'b0;
    else if (status_clr) status_q <= 1'b0;
    else if (expire_evt) status_q <= 1'b1;
  end

  assign timeout_status = status_q;
  assign timeout_irq    = status_q & irq_mask;

  // R5
  sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_status && !status_clr) |=> timeout_status);

  // R5
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_clr |=> !timeout_status);

  // R6
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mask |-> !timeout_irq);

  // R7
  zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_val == '0) |-> !expire_evt);

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !expire_evt);
endmodule

// File: tb/scl_lowtime_monitor_test.sv
module scl_lowtime_monitor_test;
  localparam int CW = 8;
  localparam int PS = 4;
  localparam int NV = 10;

  // Each vector: {limit N, edges W held low}
  localparam logic [15:0] VEC [NV] = '{
    {8'd3, 8'd13}, {8'd3, 8'd14}, {8'd1, 8'd5},  {8'd1, 8'd6},
    {8'd5, 8'd22}, {8'd5, 8'd21}, {8'd5, 8'd10}, {8'd0, 8'd40},
    {8'd2, 8'd1},  {8'd7, 8'd30}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          scl_in = 1'b1;
  logic          enable = 1'b0;
  logic [CW-1:0] timeout_val = '0;
  logic          irq_mask = 1'b0;
  logic          status_clr = 1'b0;
  logic          timeout_status;
  logic          timeout_irq;
  logic [CW-1:0] live_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  scl_lowtime_monitor #(.CNT_W(CW), .PRESCALE(PS), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .enable(enable),
    .timeout_val(timeout_val), .irq_mask(irq_mask), .status_clr(status_clr),
    .timeout_status(timeout_status), .timeout_irq(timeout_irq),
    .live_count(live_count)
  );

  // Edge at which the status should first read 1, counted from the first low sample.
  function automatic int expiry_edge(input int n);
    return 2 + PS * n;
  endfunction

  function automatic int want_count(input int n, input int w);
    int steps;
    if (w < 2) return n;
    steps = (w - 2) / PS;
    return (steps >= n) ? 0 : n - steps;
  endfunction

  function automatic bit want_status(input int n, input int w);
    return (n != 0) && (w >= expiry_edge(n));
  endfunction

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Bring the line high, clear the flag and load a new limit.
  task automatic settle(input int n);
    scl_in = 1'b1;
    status_clr = 1'b1;
    timeout_val = CW'(n);
    edges(1);
    status_clr = 1'b0;
    edges(4);
  endtask

  initial begin
    int n, w;
    edges(2);
    // R9
    check("R9 status in reset", int'(timeout_status), 0);
    check("R9 irq in reset", int'(timeout_irq), 0);
    check("R9 count in reset", int'(live_count), 0);
    rst_n = 1'b1;
    enable = 1'b1;
    edges(1);

    // Vector table: R1 expiry edge, R2 count, R6 mask, R7 zero limit
    for (int i = 0; i < NV; i++) begin
      n = int'(VEC[i][15:8]);
      w = int'(VEC[i][7:0]);
      irq_mask = i[0];
      settle(n);
      scl_in = 1'b0;
      edges(w);
      check("R1 status at edge", int'(timeout_status), int'(want_status(n, w)));
      check("R2 live count", int'(live_count), want_count(n, w));
      check("R6 masked irq", int'(timeout_irq), int'(want_status(n, w) & i[0]));
    end
    irq_mask = 1'b1;

    // R3: a one-cycle high glitch restarts the full window
    settle(3);
    scl_in = 1'b0;
    edges(10);
    scl_in = 1'b1;
    edges(1);
    scl_in = 1'b0;
    edges(expiry_edge(3) - 1);
    check("R3 no early expiry after glitch", int'(timeout_status), 0);
    check("R3 count after glitch", int'(live_count), want_count(3, expiry_edge(3) - 1));
    edges(1);
    check("R3 expiry after glitch", int'(timeout_status), 1);

    // R5: clear on the expiry edge wins; R4: no refire while held low
    settle(2);
    scl_in = 1'b0;
    edges(expiry_edge(2) - 1);
    status_clr = 1'b1;
    edges(1);
    status_clr = 1'b0;
    check("R5 clear beats set", int'(timeout_status), 0);
    check("R4 count held at zero", int'(live_count), 0);
    edges(20);
    check("R4 no second expiry", int'(timeout_status), 0);
    check("R4 still zero", int'(live_count), 0);

    // R5: sticky across a high level, cleared by strobe
    scl_in = 1'b1;
    edges(4);
    scl_in = 1'b0;
    edges(expiry_edge(2));
    check("R5 set", int'(timeout_status), 1);
    scl_in = 1'b1;
    edges(5);
    check("R5 sticky while high", int'(timeout_status), 1);
    check("R3 reload on high", int'(live_count), 2);
    status_clr = 1'b1;
    edges(1);
    status_clr = 1'b0;
    check("R5 cleared", int'(timeout_status), 0);
    check("R6 irq follows clear", int'(timeout_irq), 0);

    // R8: disabled monitor
    enable = 1'b0;
    settle(2);
    scl_in = 1'b0;
    edges(40);
    check("R8 no expiry when disabled", int'(timeout_status), 0);
    check("R8 count follows limit", int'(live_count), 2);
    enable = 1'b1;
    edges(PS * 2 - 1);
    check("R8 not yet after enable", int'(timeout_status), 0);
    edges(1);
    check("R8 expiry after enable", int'(timeout_status), 1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule